// File: doc/BRIEF.md
# Prefetch Side Buffer Controller

This block sits next to a first-level data cache. It keeps prefetched lines in a small, fully associative side buffer, apart from the cache, so a prefetch never changes what the cache holds. Demand misses and prefetches are tracked in two separate miss-tracking pools. Each cycle the controller takes at most one event: a memory response, a demand access, or a prefetch. It then forwards a request, stalls, drops, or sends a merge or credit message. The cache array, the prefetch address generator and the memory controller are outside the block. The cache reports its hit or miss as an input that comes with each access. For each fill the cache also reports its victim line and that line's dirty state.

All addresses are line addresses. Outgoing traffic leaves on one message channel with a valid/ready handshake. Each message carries a kind code, a requestor ID and a line address. The control is a three-state machine. `ST_IDLE` accepts one event. `ST_EMIT` holds a latched request, merge or credit message until `msg_ready`. `ST_WB` holds a writeback message until `msg_ready`. There are five transitions:
- IDLE→EMIT when an accepted event needs a message.
- IDLE→WB when a demand response evicts a dirty victim.
- EMIT→WB when a side-buffer hit also evicted a dirty victim.
- EMIT→IDLE and WB→IDLE once the message is taken.

Top module: `pfsb_ctrl`

## Requirements
- R1: A demand that misses the cache, the side buffer and both pools is accepted. It takes a demand pool entry and one cycle later presents a message of kind 0 (latency-critical request) carrying its ID and address.
- R2: A demand that hits the cache is accepted and produces no message.
- R3: A demand whose address is held in the demand pool is not accepted (`dem_ready` low) until the response for that address has freed the entry.
- R4: A demand that hits the side buffer is accepted. In the same cycle it fills the cache with the buffered data, and it removes the entry. It then presents a message of kind 3 (credit) with the demand's ID. A later demand to that line misses the buffer.
- R5: A demand whose address matches a pending prefetch entry is accepted. It presents a message of kind 2 (merge) carrying the prefetch's stored ID, and the entry moves to the demand pool. The later response for that line is handled as a demand response.
- R6: A prefetch is accepted and dropped, with no message, when its line hits the cache, the side buffer, either pool, or when the prefetch pool is full.
- R7: Any other prefetch takes a prefetch pool entry and presents a message of kind 1 (non-critical request) with its ID and address.
- R8: A response whose line is in the prefetch pool is written into the side buffer and frees the entry. It causes no cache fill and no message.
- R9: A response whose line is in the demand pool fills the cache in its acceptance cycle and frees the entry. If the cache reports a dirty victim, a message of kind 4 (writeback) follows, carrying the victim address and the ID stored with the entry.
- R10: The side buffer holds 8 lines. Inserting into a full buffer discards the oldest line.
- R11: The prefetch pool has 8 entries and the demand pool has 24. A full prefetch pool never blocks a demand allocation.
- R12: Events are taken in the order response, then demand, then prefetch, at most one per cycle. No input is accepted while a message is pending.
- R13: A presented message keeps its kind, ID and address unchanged until `msg_ready` is high.
- R14: After reset no message is presented, no fill is signalled, and the buffer and both pools are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dem_valid | input | 1 | Demand access present |
| dem_ready | output | 1 | Demand access accepted this cycle |
| dem_addr | input | ADDR_W | Demand line address |
| dem_id | input | ID_W | Demand requestor ID |
| dem_cache_hit | input | 1 | Cache lookup result for the demand |
| pf_valid | input | 1 | Prefetch present |
| pf_ready | output | 1 | Prefetch accepted this cycle |
| pf_addr | input | ADDR_W | Prefetch line address |
| pf_id | input | ID_W | Prefetch requestor ID |
| pf_cache_hit | input | 1 | Cache lookup result for the prefetch |
| rsp_valid | input | 1 | Memory response present |
| rsp_ready | output | 1 | Response accepted this cycle |
| rsp_addr | input | ADDR_W | Response line address |
| rsp_data | input | DATA_W | Response line data |
| fill_valid | output | 1 | Write a line into the cache this cycle |
| fill_addr | output | ADDR_W | Line address of the fill |
| fill_data | output | DATA_W | Line data of the fill |
| victim_dirty | input | 1 | Line displaced by the current fill is dirty |
| victim_addr | input | ADDR_W | Address of the displaced line |
| msg_valid | output | 1 | Outgoing message present |
| msg_ready | input | 1 | Outgoing message taken |
| msg_kind | output | 3 | 0 critical request, 1 non-critical request, 2 merge, 3 credit, 4 writeback |
| msg_id | output | ID_W | Requestor ID of the message |
| msg_addr | output | ADDR_W | Line address of the message |

## Verification
Demands are applied against five lookup outcomes: cache hit, side-buffer hit, prefetch-pool match, demand-pool match, and a full miss. The resulting message kind and the presence or absence of a fill tell these cases apart. Prefetches go through the same matches plus a full pool, which separates a real drop from a slow acceptance. Responses are sent for lines in each pool, with the victim clean or dirty, so a buffer insert can be told apart from a cache fill. Simultaneous events, a stalled message channel and nine back-to-back buffer inserts check the ordering, hold and eviction rules.

// File: rtl/pfsb_pkg.sv
package pfsb_pkg;

    typedef enum logic [2:0] {
        MSG_LC_REQ  = 3'd0,
        MSG_NLC_REQ = 3'd1,
        MSG_MERGE   = 3'd2,
        MSG_CREDIT  = 3'd3,
        MSG_WB      = 3'd4
    } msg_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EMIT,
        ST_WB
    } ctl_state_e;

endpackage

// File: rtl/pfsb_mshr_pool.sv
module pfsb_mshr_pool #(
    parameter int ENTRIES = 8,
    parameter int ADDR_W  = 26,
    parameter int ID_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic [ID_W-1:0]   lk_id,
    output logic              full,
    input  logic              alloc_en,
    input  logic [ID_W-1:0]   alloc_id,
    input  logic              free_en
);

    logic [ENTRIES-1:0] vld_q;
    logic [ADDR_W-1:0]  addr_q [ENTRIES];
    logic [ID_W-1:0]    id_q   [ENTRIES];
    logic [ENTRIES-1:0] match;
    logic [ENTRIES-1:0] free_slot;
    logic               taken;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_match
        assign match[g] = vld_q[g] && (addr_q[g] == lk_addr);
    end

    always_comb begin
        lk_id = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) lk_id = id_q[i];
        end
    end

    // lowest-numbered free entry takes the next allocation
    always_comb begin
        taken     = 1'b0;
        free_slot = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!vld_q[i] && !taken) begin
                free_slot[i] = 1'b1;
                taken        = 1'b1;
            end
        end
    end

    assign lk_hit = |match;
    assign full   = &vld_q;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_q[g]  <= 1'b0;
                addr_q[g] <= '0;
                id_q[g]   <= '0;
            end else if (free_en && match[g]) begin
                vld_q[g]  <= 1'b0;
            end else if (alloc_en && free_slot[g]) begin
                vld_q[g]  <= 1'b1;
                addr_q[g] <= lk_addr;
                id_q[g]   <= alloc_id;
            end
        end
    end

endmodule

// File: rtl/pfsb_side_buf.sv
module pfsb_side_buf #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 26,
    parameter int DATA_W = 64,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_data,
    input  logic              ins_en,
    input  logic [ADDR_W-1:0] ins_addr,
    input  logic [DATA_W-1:0] ins_data,
    input  logic              rm_en,
    output logic [CNT_W-1:0]  count
);

    // slot 0 is always the oldest line; valid slots are 0 .. cnt_q-1
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [ADDR_W-1:0] addr_d [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];
    logic [DATA_W-1:0] data_d [DEPTH];
    logic [DEPTH-1:0]  match;
    logic [IDX_W-1:0]  hit_idx;

    for (genvar g = 0; g < DEPTH; g++) begin : g_match
        assign match[g] = (CNT_W'(g) < cnt_q) && (addr_q[g] == lk_addr);
    end

    always_comb begin
        hit_idx = '0;
        lk_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (match[i]) begin
                hit_idx = IDX_W'(i);
                lk_data = data_q[i];
            end
        end
    end

    assign lk_hit = |match;
    assign count  = cnt_q;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            addr_d[i] = addr_q[i];
            data_d[i] = data_q[i];
        end
        cnt_d = cnt_q;
        if (rm_en && lk_hit) begin
            // close the gap left by the removed line
            for (int i = 0; i < DEPTH - 1; i++) begin
                if (IDX_W'(i) >= hit_idx) begin
                    addr_d[i] = addr_q[i + 1];
                    data_d[i] = data_q[i + 1];
                end
            end
            cnt_d = cnt_q - CNT_W'(1);
        end else if (ins_en) begin
            if (cnt_q == CNT_W'(DEPTH)) begin
                for (int i = 0; i < DEPTH - 1; i++) begin
                    addr_d[i] = addr_q[i + 1];
                    data_d[i] = data_q[i + 1];
                end
                addr_d[DEPTH-1] = ins_addr;
                data_d[DEPTH-1] = ins_data;
            end else begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (CNT_W'(i) == cnt_q) begin
                        addr_d[i] = ins_addr;
                        data_d[i] = ins_data;
                    end
                end
                cnt_d = cnt_q + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            addr_q[i] <= addr_d[i];
            data_q[i] <= data_d[i];
        end
    end

endmodule

// File: rtl/pfsb_ctrl.sv
module pfsb_ctrl
    import pfsb_pkg::*;
#(
    parameter int ADDR_W    = 26,
    parameter int ID_W      = 3,
    parameter int DATA_W    = 64,
    parameter int SB_DEPTH  = 8,
    parameter int PF_MSHRS  = 8,
    parameter int DEM_MSHRS = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dem_valid,
    output logic              dem_ready,
    input  logic [ADDR_W-1:0] dem_addr,
    input  logic [ID_W-1:0]   dem_id,
    input  logic              dem_cache_hit,
    input  logic              pf_valid,
    output logic              pf_ready,
    input  logic [ADDR_W-1:0] pf_addr,
    input  logic [ID_W-1:0]   pf_id,
    input  logic              pf_cache_hit,
    input  logic              rsp_valid,
    output logic              rsp_ready,
    input  logic [ADDR_W-1:0] rsp_addr,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              fill_valid,
    output logic [ADDR_W-1:0] fill_addr,
    output logic [DATA_W-1:0] fill_data,
    input  logic              victim_dirty,
    input  logic [ADDR_W-1:0] victim_addr,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [2:0]        msg_kind,
    output logic [ID_W-1:0]   msg_id,
    output logic [ADDR_W-1:0] msg_addr
);

    localparam int SB_CNT_W = $clog2(SB_DEPTH + 1);

    ctl_state_e          state_q, state_d;
    logic [ADDR_W-1:0]   lk_addr;
    logic                dm_hit, dm_full, dm_alloc, dm_free;
    logic                pm_hit, pm_full, pm_alloc, pm_free;
    logic [ID_W-1:0]     dm_id, pm_id;
    logic                sb_hit, sb_ins, sb_rm;
    logic [DATA_W-1:0]   sb_data;
    logic [SB_CNT_W-1:0] sb_count;

    logic                ld_msg, ld_wb;
    msg_kind_e           kind_d, msg_kind_q;
    logic [ID_W-1:0]     id_d, wb_id_d, msg_id_q, wb_id_q;
    logic [ADDR_W-1:0]   msg_addr_q, wb_addr_q;
    logic                wb_pend_q;

    // one event per cycle, so one shared lookup address serves every store
    assign lk_addr = rsp_valid ? rsp_addr : (dem_valid ? dem_addr : pf_addr);

    pfsb_mshr_pool #(.ENTRIES(DEM_MSHRS), .ADDR_W(ADDR_W), .ID_W(ID_W)) u_dem_pool (
        .clk(clk), .rst_n(rst_n), .lk_addr(lk_addr), .lk_hit(dm_hit), .lk_id(dm_id),
        .full(dm_full), .alloc_en(dm_alloc), .alloc_id(dem_id), .free_en(dm_free)
    );

    pfsb_mshr_pool #(.ENTRIES(PF_MSHRS), .ADDR_W(ADDR_W), .ID_W(ID_W)) u_pf_pool (
        .clk(clk), .rst_n(rst_n), .lk_addr(lk_addr), .lk_hit(pm_hit), .lk_id(pm_id),
        .full(pm_full), .alloc_en(pm_alloc), .alloc_id(pf_id), .free_en(pm_free)
    );

    pfsb_side_buf #(.DEPTH(SB_DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sbuf (
        .clk(clk), .rst_n(rst_n), .lk_addr(lk_addr), .lk_hit(sb_hit), .lk_data(sb_data),
        .ins_en(sb_ins), .ins_addr(lk_addr), .ins_data(rsp_data), .rm_en(sb_rm),
        .count(sb_count)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // message and writeback latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            msg_kind_q <= MSG_LC_REQ;
            msg_id_q   <= '0;
            msg_addr_q <= '0;
            wb_pend_q  <= 1'b0;
            wb_addr_q  <= '0;
            wb_id_q    <= '0;
        end else begin
            if (ld_msg) begin
                msg_kind_q <= kind_d;
                msg_id_q   <= id_d;
                msg_addr_q <= lk_addr;
            end
            if (ld_wb) begin
                wb_pend_q <= 1'b1;
                wb_addr_q <= victim_addr;
                wb_id_q   <= wb_id_d;
            end else if (state_q == ST_WB && msg_ready) begin
                wb_pend_q <= 1'b0;
            end
        end
    end

    // next state and outputs
    always_comb begin
        state_d    = state_q;
        dem_ready  = 1'b0;
        pf_ready   = 1'b0;
        rsp_ready  = 1'b0;
        fill_valid = 1'b0;
        fill_addr  = lk_addr;
        fill_data  = rsp_data;
        dm_alloc   = 1'b0;
        dm_free    = 1'b0;
        pm_alloc   = 1'b0;
        pm_free    = 1'b0;
        sb_ins     = 1'b0;
        sb_rm      = 1'b0;
        ld_msg     = 1'b0;
        ld_wb      = 1'b0;
        kind_d     = MSG_LC_REQ;
        id_d       = dem_id;
        wb_id_d    = dem_id;
        msg_valid  = 1'b0;
        msg_kind   = msg_kind_q;
        msg_id     = msg_id_q;
        msg_addr   = msg_addr_q;

        unique case (state_q)
            ST_IDLE: begin
                if (rsp_valid) begin
                    rsp_ready = 1'b1;
                    if (dm_hit) begin
                        dm_free    = 1'b1;
                        fill_valid = 1'b1;
                        if (victim_dirty) begin
                            ld_wb   = 1'b1;
                            wb_id_d = dm_id;
                            state_d = ST_WB;
                        end
                    end else if (pm_hit) begin
                        pm_free = 1'b1;
                        sb_ins  = 1'b1;
                    end
                end else if (dem_valid) begin
                    if (dem_cache_hit) begin
                        dem_ready = 1'b1;
                    end else if (dm_hit) begin
                        dem_ready = 1'b0;
                    end else if (sb_hit) begin
                        dem_ready  = 1'b1;
                        sb_rm      = 1'b1;
                        fill_valid = 1'b1;
                        fill_data  = sb_data;
                        ld_msg     = 1'b1;
                        kind_d     = MSG_CREDIT;
                        ld_wb      = victim_dirty;
                        state_d    = ST_EMIT;
                    end else if (!dm_full) begin
                        dem_ready = 1'b1;
                        dm_alloc  = 1'b1;
                        ld_msg    = 1'b1;
                        state_d   = ST_EMIT;
                        if (pm_hit) begin
                            pm_free = 1'b1;
                            kind_d  = MSG_MERGE;
                            id_d    = pm_id;
                        end
                    end
                end else if (pf_valid) begin
                    pf_ready = 1'b1;
                    if (!(pf_cache_hit || sb_hit || pm_hit || dm_hit || pm_full)) begin
                        pm_alloc = 1'b1;
                        ld_msg   = 1'b1;
                        kind_d   = MSG_NLC_REQ;
                        id_d     = pf_id;
                        state_d  = ST_EMIT;
                    end
                end
            end
            ST_EMIT: begin
                msg_valid = 1'b1;
                if (msg_ready) state_d = wb_pend_q ? ST_WB : ST_IDLE;
            end
            ST_WB: begin
                msg_valid = 1'b1;
                msg_kind  = MSG_WB;
                msg_id    = wb_id_q;
                msg_addr  = wb_addr_q;
                if (msg_ready) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/pfsb_ctrl_chk.sv
module pfsb_ctrl_chk #(
    parameter int ADDR_W   = 26,
    parameter int ID_W     = 3,
    parameter int SB_DEPTH = 8,
    localparam int SB_CNT_W = $clog2(SB_DEPTH + 1)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                dem_valid,
    input logic                dem_ready,
    input logic                dem_cache_hit,
    input logic                pf_valid,
    input logic                pf_ready,
    input logic                pf_cache_hit,
    input logic                rsp_valid,
    input logic                rsp_ready,
    input logic                fill_valid,
    input logic                victim_dirty,
    input logic                msg_valid,
    input logic                msg_ready,
    input logic [2:0]          msg_kind,
    input logic [ID_W-1:0]     msg_id,
    input logic [ADDR_W-1:0]   msg_addr,
    input logic                dm_hit,
    input logic                pm_hit,
    input logic                sb_hit,
    input logic [SB_CNT_W-1:0] sb_count
);

    p_msg_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_kind) && $stable(msg_id) && $stable(msg_addr));

    p_busy_no_accept_r12: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> !dem_ready && !pf_ready && !rsp_ready);

    p_single_event_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dem_valid && dem_ready, pf_valid && pf_ready, rsp_valid && rsp_ready}));

    p_dem_before_pf_r12: assert property (@(posedge clk) disable iff (!rst_n)
        dem_valid |-> !pf_ready);

    p_lc_request_r1: assert property (@(posedge clk) disable iff (!rst_n)
        dem_valid && dem_ready && !dem_cache_hit && !sb_hit && !pm_hit |=> msg_valid && msg_kind == 3'd0);

    p_cache_hit_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dem_valid && dem_ready && dem_cache_hit |=> !msg_valid);

    p_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dem_valid && dm_hit && !dem_cache_hit |-> !dem_ready);

    p_credit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dem_valid && dem_ready && !dem_cache_hit && sb_hit |=> msg_valid && msg_kind == 3'd3);

    p_merge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dem_valid && dem_ready && !dem_cache_hit && !sb_hit && pm_hit |=> msg_valid && msg_kind == 3'd2);

    p_pf_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid && pf_ready && (pf_cache_hit || sb_hit || pm_hit || dm_hit) |=> !msg_valid);

    p_writeback_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_ready && fill_valid && victim_dirty |=> msg_valid && msg_kind == 3'd4);

    p_sb_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sb_count <= SB_CNT_W'(SB_DEPTH));

    p_fill_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |-> (rsp_valid && rsp_ready) || (dem_valid && dem_ready));

endmodule

bind pfsb_ctrl pfsb_ctrl_chk #(.ADDR_W(ADDR_W), .ID_W(ID_W), .SB_DEPTH(SB_DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .dem_valid(dem_valid), .dem_ready(dem_ready),
    .dem_cache_hit(dem_cache_hit), .pf_valid(pf_valid), .pf_ready(pf_ready),
    .pf_cache_hit(pf_cache_hit), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .fill_valid(fill_valid), .victim_dirty(victim_dirty), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_kind(msg_kind), .msg_id(msg_id), .msg_addr(msg_addr),
    .dm_hit(dm_hit), .pm_hit(pm_hit), .sb_hit(sb_hit), .sb_count(sb_count)
);

// File: tb/pfsb_ctrl_test.sv
module pfsb_ctrl_test;

    localparam int AW = 26;
    localparam int IW = 3;
    localparam int DW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dem_valid = 1'b0, dem_ready, dem_cache_hit = 1'b0;
    logic [AW-1:0] dem_addr = '0;
    logic [IW-1:0] dem_id = '0;
    logic          pf_valid = 1'b0, pf_ready, pf_cache_hit = 1'b0;
    logic [AW-1:0] pf_addr = '0;
    logic [IW-1:0] pf_id = '0;
    logic          rsp_valid = 1'b0, rsp_ready;
    logic [AW-1:0] rsp_addr = '0;
    logic [DW-1:0] rsp_data = '0;
    logic          fill_valid;
    logic [AW-1:0] fill_addr;
    logic [DW-1:0] fill_data;
    logic          victim_dirty = 1'b0;
    logic [AW-1:0] victim_addr = '0;
    logic          msg_valid, msg_ready = 1'b1;
    logic [2:0]    msg_kind;
    logic [IW-1:0] msg_id;
    logic [AW-1:0] msg_addr;

    int n_chk = 0;
    int n_fail = 0;

    logic          s_dr, s_pr, s_rr, s_fv, s_mv;
    logic [AW-1:0] s_fa, s_ma;
    logic [DW-1:0] s_fd;
    logic [2:0]    s_mk;
    logic [IW-1:0] s_mi;

    always #4 clk = ~clk;

    pfsb_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .dem_valid(dem_valid), .dem_ready(dem_ready), .dem_addr(dem_addr), .dem_id(dem_id),
        .dem_cache_hit(dem_cache_hit),
        .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr), .pf_id(pf_id),
        .pf_cache_hit(pf_cache_hit),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr), .rsp_data(rsp_data),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data),
        .victim_dirty(victim_dirty), .victim_addr(victim_addr),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_kind(msg_kind),
        .msg_id(msg_id), .msg_addr(msg_addr)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_dem(input logic [AW-1:0] a, input logic [IW-1:0] id, input logic ch);
        dem_valid = 1'b1; dem_addr = a; dem_id = id; dem_cache_hit = ch;
    endtask

    task automatic set_pf(input logic [AW-1:0] a, input logic [IW-1:0] id, input logic ch);
        pf_valid = 1'b1; pf_addr = a; pf_id = id; pf_cache_hit = ch;
    endtask

    task automatic set_rsp(input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input logic vd, input logic [AW-1:0] va);
        rsp_valid = 1'b1; rsp_addr = a; rsp_data = d; victim_dirty = vd; victim_addr = va;
    endtask

    // sample acceptance and fill in the event cycle, the message one cycle later
    task automatic fire();
        #1;
        s_dr = dem_ready; s_pr = pf_ready; s_rr = rsp_ready;
        s_fv = fill_valid; s_fa = fill_addr; s_fd = fill_data;
        step();
        dem_valid = 1'b0; pf_valid = 1'b0; rsp_valid = 1'b0; victim_dirty = 1'b0;
        s_mv = msg_valid; s_mk = msg_kind; s_mi = msg_id; s_ma = msg_addr;
    endtask

    task automatic drain();
        while (msg_valid) step();
    endtask

    task automatic t_reset();
        #1;
        check("R14 msg_valid after reset", msg_valid, 1'b0);
        check("R14 fill_valid after reset", fill_valid, 1'b0);
        check("R14 dem_ready idle", dem_ready, 1'b0);
    endtask

    task automatic t_demand_miss();
        set_dem(26'h100, 3'd2, 1'b0);
        fire();
        check("R1 demand accepted", s_dr, 1'b1);
        check("R1 no fill", s_fv, 1'b0);
        check("R1 msg valid", s_mv, 1'b1);
        check("R1 kind", s_mk, 3'd0);
        check("R1 id", s_mi, 3'd2);
        check("R1 addr", s_ma, 26'h100);
        drain();
    endtask

    task automatic t_cache_hit();
        set_dem(26'h200, 3'd2, 1'b1);
        fire();
        check("R2 accepted", s_dr, 1'b1);
        check("R2 no msg", s_mv, 1'b0);
    endtask

    task automatic t_stall_and_fill();
        set_dem(26'h100, 3'd2, 1'b0);
        #1;
        check("R3 stalled", dem_ready, 1'b0);
        step();
        #1;
        check("R3 still stalled", dem_ready, 1'b0);
        step();
        dem_valid = 1'b0;
        set_rsp(26'h100, 64'hD1, 1'b0, '0);
        fire();
        check("R9 rsp accepted", s_rr, 1'b1);
        check("R9 fill valid", s_fv, 1'b1);
        check("R9 fill addr", s_fa, 26'h100);
        check("R9 fill data", s_fd, 64'hD1);
        check("R9 clean victim no msg", s_mv, 1'b0);
        set_dem(26'h100, 3'd2, 1'b0);
        fire();
        check("R3 accepted after free", s_dr, 1'b1);
        check("R3 new request kind", s_mk, 3'd0);
        drain();
    endtask

    task automatic t_dirty_writeback();
        set_rsp(26'h100, 64'hD2, 1'b1, 26'h3F0);
        fire();
        check("R9 dirty fill", s_fv, 1'b1);
        check("R9 wb valid", s_mv, 1'b1);
        check("R9 wb kind", s_mk, 3'd4);
        check("R9 wb addr", s_ma, 26'h3F0);
        check("R9 wb id", s_mi, 3'd2);
        drain();
    endtask

    task automatic t_prefetch_paths();
        set_pf(26'h500, 3'd5, 1'b0);
        fire();
        check("R7 accepted", s_pr, 1'b1);
        check("R7 kind", s_mk, 3'd1);
        check("R7 id", s_mi, 3'd5);
        check("R7 addr", s_ma, 26'h500);
        drain();
        set_pf(26'h500, 3'd5, 1'b0);
        fire();
        check("R6 pool dup accepted", s_pr, 1'b1);
        check("R6 pool dup no msg", s_mv, 1'b0);
        set_rsp(26'h500, 64'hD3, 1'b0, '0);
        fire();
        check("R8 rsp accepted", s_rr, 1'b1);
        check("R8 no fill", s_fv, 1'b0);
        check("R8 no msg", s_mv, 1'b0);
        set_pf(26'h500, 3'd5, 1'b0);
        fire();
        check("R6 buffer dup no msg", s_mv, 1'b0);
        set_pf(26'h600, 3'd5, 1'b1);
        fire();
        check("R6 cache hit accepted", s_pr, 1'b1);
        check("R6 cache hit no msg", s_mv, 1'b0);
    endtask

    task automatic t_side_hit();
        set_dem(26'h500, 3'd2, 1'b0);
        fire();
        check("R4 accepted", s_dr, 1'b1);
        check("R4 fill", s_fv, 1'b1);
        check("R4 fill data", s_fd, 64'hD3);
        check("R4 credit kind", s_mk, 3'd3);
        check("R4 credit id", s_mi, 3'd2);
        check("R4 credit addr", s_ma, 26'h500);
        drain();
        set_dem(26'h500, 3'd2, 1'b0);
        fire();
        check("R4 entry removed", s_mk, 3'd0);
        check("R4 entry removed no fill", s_fv, 1'b0);
        drain();
        set_rsp(26'h500, 64'hD4, 1'b0, '0);
        fire();
    endtask

    task automatic t_merge();
        set_pf(26'h700, 3'd5, 1'b0);
        fire();
        drain();
        set_dem(26'h700, 3'd2, 1'b0);
        fire();
        check("R5 accepted", s_dr, 1'b1);
        check("R5 merge kind", s_mk, 3'd2);
        check("R5 merge id", s_mi, 3'd5);
        check("R5 merge addr", s_ma, 26'h700);
        drain();
        set_rsp(26'h700, 64'hD5, 1'b0, '0);
        fire();
        check("R5 response fills cache", s_fv, 1'b1);
        check("R5 fill data", s_fd, 64'hD5);
    endtask

    task automatic t_priority();
        set_dem(26'h800, 3'd1, 1'b0);
        set_pf(26'h900, 3'd5, 1'b0);
        fire();
        check("R12 demand first", s_dr, 1'b1);
        check("R12 prefetch waits", s_pr, 1'b0);
        check("R12 demand msg", s_ma, 26'h800);
        drain();
        set_rsp(26'h800, 64'hD6, 1'b0, '0);
        set_dem(26'hA00, 3'd1, 1'b0);
        fire();
        check("R12 response first", s_rr, 1'b1);
        check("R12 demand waits", s_dr, 1'b0);
        check("R12 response fill", s_fv, 1'b1);
    endtask

    task automatic t_backpressure();
        msg_ready = 1'b0;
        set_dem(26'hB00, 3'd3, 1'b0);
        fire();
        check("R13 msg presented", s_mv, 1'b1);
        set_dem(26'hC00, 3'd3, 1'b1);
        #1;
        check("R12 busy blocks input", dem_ready, 1'b0);
        step();
        step();
        check("R13 still valid", msg_valid, 1'b1);
        check("R13 addr held", msg_addr, 26'hB00);
        check("R13 kind held", msg_kind, 3'd0);
        dem_valid = 1'b0;
        msg_ready = 1'b1;
        drain();
    endtask

    task automatic t_fifo_evict();
        for (int k = 0; k < 9; k++) begin
            set_pf(26'h1000 + 26'(k), 3'd5, 1'b0);
            fire();
            drain();
            set_rsp(26'h1000 + 26'(k), 64'hE0 + 64'(k), 1'b0, '0);
            fire();
        end
        set_dem(26'h1000, 3'd2, 1'b0);
        fire();
        check("R10 oldest evicted", s_mk, 3'd0);
        check("R10 oldest no fill", s_fv, 1'b0);
        drain();
        set_dem(26'h1001, 3'd2, 1'b0);
        fire();
        check("R10 second kept", s_mk, 3'd3);
        check("R10 second data", s_fd, 64'hE1);
        drain();
        set_rsp(26'h1000, 64'hF0, 1'b0, '0);
        fire();
    endtask

    task automatic t_pool_split();
        for (int k = 0; k < 8; k++) begin
            set_pf(26'h2000 + 26'(k), 3'd4, 1'b0);
            fire();
            drain();
        end
        set_pf(26'h2008, 3'd4, 1'b0);
        fire();
        check("R6 full pool accepted", s_pr, 1'b1);
        check("R6 full pool no msg", s_mv, 1'b0);
        set_dem(26'h3000, 3'd1, 1'b0);
        fire();
        check("R11 demand with prefetch pool full", s_dr, 1'b1);
        check("R11 demand request kind", s_mk, 3'd0);
        drain();
        for (int k = 0; k < 8; k++) begin
            set_rsp(26'h2000 + 26'(k), 64'h0, 1'b0, '0);
            fire();
        end
        set_rsp(26'h3000, 64'hAB, 1'b0, '0);
        fire();
        check("R11 demand response fill", s_fv, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_demand_miss();
        t_cache_hit();
        t_stall_and_fill();
        t_dirty_writeback();
        t_prefetch_paths();
        t_side_hit();
        t_merge();
        t_priority();
        t_backpressure();
        t_fifo_evict();
        t_pool_split();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule